// File: doc/BRIEF.md
# Operand Forwarding Select for a Four-Stage Pipeline

This block decides, for each of the two source operands of the instruction in the register-read stage, where the operand value comes from. The pipeline has four stages: fetch, register read, ALU and write-back. The register file is split into two parts. Its read port is combinational and is used in the register-read stage. Its write port is clocked and commits at the end of the write-back stage. A value that an older instruction is still computing is therefore not yet in the register file when a younger instruction reads it.

The block compares the source register numbers against two destinations. The first is the destination of the instruction in the ALU stage, whose result is live on the ALU output. The second is the write address of the write-back stage, whose data is being written during this cycle and so cannot yet be read back. A match with the ALU stage is preferred, because it is the younger producer. The all-ones register always reads as zero and is never forwarded. The ALU path is taken only when the ALU-stage instruction produces its result in the ALU; a load in that stage has no data yet. The block drives both the select codes and the selected operand values.

The block is purely combinational. It sits between the register-file read ports and the ALU input registers.

Top module: `operand_bypass`

## Requirements
- R1: Instruction classes (3 bits) are 0 none, 1 register-form ALU operation, 2 constant-form ALU operation, 3 load, 4 store, 5 branch, 6 jump, 7 PC-relative load. The A source is read by classes 1 to 6. If A is read, rs_ra is not the all-ones register, ex_class is 1 or 2, and rs_ra equals ex_rc, then sel_a is 1 and opnd_a equals ex_result.
- R2: If A is read, rs_ra is not the all-ones register, R1 does not apply, wb_we is 1 and rs_ra equals wb_wa, then sel_a is 2 and opnd_a equals wb_data.
- R3: When the ALU-stage and write-back matches both hold, the ALU-stage result wins (sel code 1).
- R4: A read source equal to the all-ones register gives sel code 3 and an operand of zero, whatever the stage matches are.
- R5: In every other case, including an operand that the class does not read, the sel code is 0 and the operand equals the register-file read value (rf_a or rf_b).
- R6: The B source follows the same rules as R1 to R5, using rs_rb and rf_b, and is read only by classes 1 and 4.
- R7: An ALU-stage instruction of class 0 or 3 to 7 never selects the ALU-stage result, even when its destination matches. The operand then falls back to the write-back match or to the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_class | input | 3 | Class of the register-stage instruction |
| rs_ra | input | AW | Register-stage A source number |
| rs_rb | input | AW | Register-stage B source number |
| ex_class | input | 3 | Class of the ALU-stage instruction |
| ex_rc | input | AW | ALU-stage destination number |
| ex_result | input | W | ALU output of the ALU stage |
| wb_we | input | 1 | Write-back write enable |
| wb_wa | input | AW | Write-back write address |
| wb_data | input | W | Write-back data |
| rf_a | input | W | Register-file read value for A |
| rf_b | input | W | Register-file read value for B |
| sel_a | output | 2 | A source: 0 file, 1 ALU, 2 write-back, 3 zero |
| sel_b | output | 2 | B source, same coding |
| opnd_a | output | W | Selected A operand |
| opnd_b | output | W | Selected B operand |

## Verification
The bench builds the block with AW=2 and W=8. With these values there are four registers, and register 3 plays the role of the always-zero register. This size makes the full input space of classes and register numbers small enough to sweep exhaustively. Every combination of both stage classes, all source, destination and write addresses and both write-enable values is applied. As a result, every priority overlap, every zero-register collision and every load-in-ALU-stage case is reached for both operands.

// File: rtl/operand_bypass.sv
module operand_bypass #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic [2:0]    rs_class,
  input  logic [AW-1:0] rs_ra,
  input  logic [AW-1:0] rs_rb,
  input  logic [2:0]    ex_class,
  input  logic [AW-1:0] ex_rc,
  input  logic [W-1:0]  ex_result,
  input  logic          wb_we,
  input  logic [AW-1:0] wb_wa,
  input  logic [W-1:0]  wb_data,
  input  logic [W-1:0]  rf_a,
  input  logic [W-1:0]  rf_b,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [W-1:0]  opnd_a,
  output logic [W-1:0]  opnd_b
);
  localparam logic [AW-1:0] ZREG = '1;
  localparam logic [1:0] S_RF = 2'd0, S_EX = 2'd1, S_WB = 2'd2, S_ZERO = 2'd3;

  wire ex_alu  = (ex_class == 3'd1) || (ex_class == 3'd2);
  wire reads_a = (rs_class != 3'd0) && (rs_class != 3'd7);
  wire reads_b = (rs_class == 3'd1) || (rs_class == 3'd4);

  function automatic logic [1:0] pick(input logic rd, input logic [AW-1:0] src,
                                      input logic alu_ok, input logic [AW-1:0] rc,
                                      input logic we, input logic [AW-1:0] wa);
    if (!rd)                    return S_RF;
    if (src == ZREG)            return S_ZERO;
    if (alu_ok && src == rc)    return S_EX;
    if (we && src == wa)        return S_WB;
    return S_RF;
  endfunction

  function automatic logic [W-1:0] route(input logic [1:0] s, input logic [W-1:0] ex,
                                         input logic [W-1:0] wb, input logic [W-1:0] rf);
    case (s)
      S_EX:    return ex;
      S_WB:    return wb;
      S_ZERO:  return '0;
      default: return rf;
    endcase
  endfunction

  assign sel_a  = pick(reads_a, rs_ra, ex_alu, ex_rc, wb_we, wb_wa);
  assign sel_b  = pick(reads_b, rs_rb, ex_alu, ex_rc, wb_we, wb_wa);
  assign opnd_a = route(sel_a, ex_result, wb_data, rf_a);
  assign opnd_b = route(sel_b, ex_result, wb_data, rf_b);

  always_comb begin
    if (sel_a == S_EX)
      a_r1_alu_path_valid: assert (rs_ra == ex_rc && rs_ra != ZREG && opnd_a == ex_result);
    if (sel_a == S_WB)
      a_r2_wb_path_valid: assert (wb_we && rs_ra == wb_wa && opnd_a == wb_data);
    if (sel_a == S_WB)
      a_r3_alu_first: assert (!((ex_class == 3'd1 || ex_class == 3'd2) && rs_ra == ex_rc));
    if (reads_a && rs_ra == ZREG)
      a_r4_zero_reg: assert (sel_a == S_ZERO && opnd_a == '0);
    if (sel_b != S_RF)
      a_r6_b_needs_read: assert (rs_class == 3'd1 || rs_class == 3'd4);
    if (!(ex_class == 3'd1 || ex_class == 3'd2))
      a_r7_no_load_fwd: assert (sel_a != S_EX && sel_b != S_EX);
  end
endmodule

// File: tb/operand_bypass_test.sv
module operand_bypass_test;
  localparam int W = 8, AW = 2;
  localparam int ZR = (1 << AW) - 1;

  logic clk = 0;
  always #4 clk = ~clk;

  logic [2:0] rs_class, ex_class;
  logic [AW-1:0] rs_ra, rs_rb, ex_rc, wb_wa;
  logic wb_we;
  logic [W-1:0] ex_result, wb_data, rf_a, rf_b;
  logic [1:0] sel_a, sel_b;
  logic [W-1:0] opnd_a, opnd_b;

  int checks = 0, fails = 0;

  operand_bypass #(.W(W), .AW(AW)) uut (
    .rs_class(rs_class), .rs_ra(rs_ra), .rs_rb(rs_rb),
    .ex_class(ex_class), .ex_rc(ex_rc), .ex_result(ex_result),
    .wb_we(wb_we), .wb_wa(wb_wa), .wb_data(wb_data),
    .rf_a(rf_a), .rf_b(rf_b),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b));

  task automatic expect_src(input bit rd, input int src, input logic [W-1:0] rf,
                            output int s, output logic [W-1:0] v, output string tag);
    bit exm, wbm;
    exm = (ex_class == 1 || ex_class == 2) && src == ex_rc;
    wbm = wb_we && src == wb_wa;
    if (!rd) begin s = 0; v = rf; tag = "R5"; end
    else if (src == ZR) begin s = 3; v = 0; tag = "R4"; end
    else if (exm) begin s = 1; v = ex_result; tag = wbm ? "R3" : "R1"; end
    else if (wbm) begin s = 2; v = wb_data; tag = (src == ex_rc) ? "R7" : "R2"; end
    else begin s = 0; v = rf; tag = (src == ex_rc) ? "R7" : "R5"; end
  endtask

  task automatic check_all();
    int s; logic [W-1:0] v; string tag;
    bit rda, rdb;
    rda = rs_class != 0 && rs_class != 7;
    rdb = rs_class == 1 || rs_class == 4;
    expect_src(rda, int'(rs_ra), rf_a, s, v, tag);
    checks++;
    if (sel_a != s[1:0] || opnd_a != v) begin
      fails++;
      $display("FAIL %s operand A: sel=%0d opnd=%h expected sel=%0d opnd=%h", tag, sel_a, opnd_a, s, v);
    end
    expect_src(rdb, int'(rs_rb), rf_b, s, v, tag);
    checks++;
    if (sel_b != s[1:0] || opnd_b != v) begin
      fails++;
      $display("FAIL R6/%s operand B: sel=%0d opnd=%h expected sel=%0d opnd=%h", tag, sel_b, opnd_b, s, v);
    end
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    ex_result = 8'hA1; wb_data = 8'hB2; rf_a = 8'hC3; rf_b = 8'hD4;
    rs_class = 0; ex_class = 0; rs_ra = 0; rs_rb = 0; ex_rc = 0; wb_we = 0; wb_wa = 0;
    @(posedge clk); #2;
    check_all();
    for (int rc = 0; rc < 8; rc++)
      for (int ec = 0; ec < 8; ec++)
        for (int a = 0; a <= ZR; a++)
          for (int b = 0; b <= ZR; b++)
            for (int d = 0; d <= ZR; d++)
              for (int we = 0; we < 2; we++)
                for (int wa = 0; wa <= ZR; wa++) begin
                  @(posedge clk); #1;
                  rs_class = rc[2:0]; ex_class = ec[2:0];
                  rs_ra = a[AW-1:0]; rs_rb = b[AW-1:0]; ex_rc = d[AW-1:0];
                  wb_we = we[0]; wb_wa = wa[AW-1:0];
                  rf_a = 8'hC0 ^ 8'(a * 5 + rc);
                  rf_b = 8'hD0 ^ 8'(b * 3 + ec);
                  #2;
                  check_all();
                end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule